// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder with Round-to-Nearest-Even

This block adds or subtracts two 32-bit binary floating-point numbers in a three-stage pipeline. Each word holds the sign in bit 31, an 8-bit biased exponent in bits 30..23 and a 23-bit fraction in bits 22..0. For a normal number the value is (-1)^sign x (1 + fraction) x 2^(exponent - 127). Subtraction is an addition with the sign of the second operand inverted.

Stage one unpacks both words, restores the hidden one and orders the operands by magnitude. It then shifts the smaller significand right by the exponent difference. Three extra low bits are kept: guard, round, and a sticky bit that records any nonzero bit shifted out below them. Stage two adds or subtracts the aligned significands. It renormalises with a one-place right shift on carry or a leading-zero left shift, and adjusts the exponent to match. Stage three rounds to nearest with ties to even, renormalises again if rounding carries out, checks the exponent range and packs the result.

The pipeline accepts one operation per cycle. It flushes out-of-range results to a signed infinity or a signed zero and raises a flag. Inputs with a zero exponent field count as zero.

Top module: `fp_add_rne`

## Requirements
- R1: The result is packed as sign in bit 31, biased exponent (bias 127) in bits 30..23 and fraction in bits 22..0. For example 0.25 - 1.0 yields 0xBF400000 (-0.75: sign 1, exponent 126, fraction 0x400000).
- R2: out_valid_o rises exactly three clock cycles after in_valid_i is sampled high. A new operation may be issued every cycle. ovf_o and unf_o are only ever high together with out_valid_o.
- R3: The operand with the smaller exponent is aligned right, and the sum is renormalised. 0.5 + (-0.4375) gives 0x3D800000 (0.0625) whichever operand comes first, and 1.5 + 1.5 gives 0x40400000.
- R4: With sub_i = 1 the block computes a_i - b_i. For example 1.0 - 0.25 gives 0x3F400000.
- R5: A result exactly halfway between two representable values rounds to the one whose fraction LSB is 0. So 1.0 + 2^-24 gives 0x3F800000, and 0x3F800001 + 2^-24 gives 0x3F800002.
- R6: Bits shifted out below the round position set the sticky bit. A remainder above one half ULP rounds up, and one below one half ULP rounds down, in both addition and subtraction, even for exponent differences larger than the significand.
- R7: When rounding carries out of the significand, the result is renormalised and the exponent increments. For example 0x3FFFFFFF + 2^-24 gives 0x40000000.
- R8: If the final exponent reaches 255 (including after rounding), ovf_o is set and the result is a signed infinity: exponent 255, fraction 0.
- R9: If the normalised exponent falls below 1, unf_o is set and the result is a zero carrying the sign of the larger-magnitude operand.
- R10: An input whose exponent field is 0 is treated as zero regardless of its fraction. An exact zero sum yields +0 (0x00000000) with no flag raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operands valid this cycle |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| sub_i | input | 1 | 1: compute a_i - b_i, 0: a_i + b_i |
| out_valid_o | output | 1 | Result valid |
| sum_o | output | 32 | Rounded, packed result |
| ovf_o | output | 1 | Exponent overflow, result is signed infinity |
| unf_o | output | 1 | Exponent underflow, result is signed zero |

## Verification
Rounding and range checking meet in the final stage. A round-up carry can push the exponent from 254 to 255, so the post-rounding renormalisation and the overflow decision happen in the same cycle. This is provoked by adding exactly half an ULP to the largest finite value, 0x7F7FFFFF + 0x73000000: the tie rounds up because the LSB is odd. The result is judged correct only if the output is 0x7F800000 with ovf_o high. A sibling case, 0x3FFFFFFF + 2^-24, exercises the same carry without overflow and must give 0x40000000 with both flags low.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
  localparam int FP_EXP_W = 8;
  localparam int FP_MAN_W = 23;
  localparam int GRS_W    = 3;   // guard, round, sticky
endpackage

// File: rtl/fpa_lzc.sv
module fpa_lzc #(
  parameter int W  = 27,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  d_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (d_i[i]) cnt_o = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fpa_align.sv
module fpa_align
  import fpa_pkg::*;
#(
  parameter int EXP_W = FP_EXP_W,
  parameter int MAN_W = FP_MAN_W,
  localparam int W  = 1 + EXP_W + MAN_W,
  localparam int M  = MAN_W + 1,
  localparam int SW = M + GRS_W,
  localparam int WW = 2 * M + 2
) (
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  logic             sub_i,
  output logic             sign_o,
  output logic [EXP_W-1:0] exp_o,
  output logic [SW-1:0]    big_o,
  output logic [SW-1:0]    small_o,
  output logic             eff_sub_o,
  output logic             zero_o
);
  logic             a_zero, b_zero, sa, sb, swap;
  logic [W-2:0]     mag_a, mag_b;
  logic [M-1:0]     sig_a, sig_b, sig_big, sig_small;
  logic [EXP_W-1:0] ea, eb, e_small, diff;
  logic [WW-1:0]    wide, shifted;
  logic             sticky;

  always_comb begin
    ea     = a_i[MAN_W +: EXP_W];
    eb     = b_i[MAN_W +: EXP_W];
    a_zero = (ea == '0);
    b_zero = (eb == '0);
    sa     = a_i[W-1];
    sb     = b_i[W-1] ^ sub_i;
    mag_a  = a_zero ? '0 : a_i[W-2:0];
    mag_b  = b_zero ? '0 : b_i[W-2:0];
    sig_a  = a_zero ? '0 : {1'b1, a_i[MAN_W-1:0]};
    sig_b  = b_zero ? '0 : {1'b1, b_i[MAN_W-1:0]};
    swap   = (mag_b > mag_a);

    sign_o    = swap ? sb : sa;
    exp_o     = swap ? eb : ea;
    e_small   = swap ? ea : eb;
    sig_big   = swap ? sig_b : sig_a;
    sig_small = swap ? sig_a : sig_b;
    eff_sub_o = sa ^ sb;
    zero_o    = a_zero & b_zero;
    diff      = exp_o - e_small;

    wide    = {sig_small, {(M + 2){1'b0}}};
    shifted = wide >> diff;
    // beyond M+2 places every significand bit lies below the round position
    if (int'(diff) > M + 2) begin
      sticky  = |sig_small;
      small_o = {{(SW - 1){1'b0}}, sticky};
    end else begin
      sticky  = |shifted[M-1:0];
      small_o = {shifted[WW-1 -: M + 2], sticky};
    end
    big_o = {sig_big, {GRS_W{1'b0}}};
  end
endmodule

// File: rtl/fpa_addnorm.sv
module fpa_addnorm
  import fpa_pkg::*;
#(
  parameter int EXP_W = FP_EXP_W,
  parameter int MAN_W = FP_MAN_W,
  localparam int M  = MAN_W + 1,
  localparam int SW = M + GRS_W,
  localparam int EW = EXP_W + 2,
  localparam int CW = $clog2(SW + 1)
) (
  input  logic                 sign_i,
  input  logic [EXP_W-1:0]     exp_i,
  input  logic [SW-1:0]        big_i,
  input  logic [SW-1:0]        small_i,
  input  logic                 eff_sub_i,
  input  logic                 zero_i,
  output logic                 sign_o,
  output logic signed [EW-1:0] exp_o,
  output logic [SW-1:0]        norm_o,
  output logic                 zero_o
);
  logic [SW:0]          raw;
  logic [CW-1:0]        lz;
  logic signed [EW-1:0] e_base;

  fpa_lzc #(.W(SW)) i_lzc (.d_i(raw[SW-1:0]), .cnt_o(lz));

  always_comb begin
    raw    = eff_sub_i ? ({1'b0, big_i} - {1'b0, small_i})
                       : ({1'b0, big_i} + {1'b0, small_i});
    e_base = signed'({2'b00, exp_i});
    zero_o = zero_i | (raw == '0);
    sign_o = zero_o ? 1'b0 : sign_i;
    if (raw[SW]) begin
      norm_o = {raw[SW:2], raw[1] | raw[0]};
      exp_o  = e_base + EW'(1);
    end else begin
      norm_o = raw[SW-1:0] << lz;
      exp_o  = e_base - signed'(EW'(lz));
    end
  end
endmodule

// File: rtl/fpa_round.sv
module fpa_round
  import fpa_pkg::*;
#(
  parameter int EXP_W = FP_EXP_W,
  parameter int MAN_W = FP_MAN_W,
  localparam int W  = 1 + EXP_W + MAN_W,
  localparam int M  = MAN_W + 1,
  localparam int SW = M + GRS_W,
  localparam int EW = EXP_W + 2,
  localparam logic signed [EW-1:0] EMAX = EW'((1 << EXP_W) - 1)
) (
  input  logic                 sign_i,
  input  logic signed [EW-1:0] exp_i,
  input  logic [SW-1:0]        norm_i,
  input  logic                 zero_i,
  output logic [W-1:0]         res_o,
  output logic                 ovf_o,
  output logic                 unf_o
);
  logic                 lsb, g, rs, up;
  logic [M:0]           rnd;
  logic [M-1:0]         mant;
  logic signed [EW-1:0] e;

  always_comb begin
    lsb  = norm_i[GRS_W];
    g    = norm_i[GRS_W-1];
    rs   = |norm_i[GRS_W-2:0];
    up   = g & (rs | lsb);
    rnd  = {1'b0, norm_i[SW-1:GRS_W]} + (M + 1)'(up);
    if (rnd[M]) begin
      mant = rnd[M:1];
      e    = exp_i + EW'(1);
    end else begin
      mant = rnd[M-1:0];
      e    = exp_i;
    end
    ovf_o = 1'b0;
    unf_o = 1'b0;
    if (zero_i) begin
      res_o = '0;
    end else if (e >= EMAX) begin
      ovf_o = 1'b1;
      res_o = {sign_i, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
    end else if (e < signed'(EW'(1))) begin
      unf_o = 1'b1;
      res_o = {sign_i, {(W - 1){1'b0}}};
    end else begin
      res_o = {sign_i, e[EXP_W-1:0], mant[MAN_W-1:0]};
    end
  end
endmodule

// File: rtl/fp_add_rne.sv
module fp_add_rne
  import fpa_pkg::*;
#(
  parameter int EXP_W = FP_EXP_W,
  parameter int MAN_W = FP_MAN_W,
  localparam int W  = 1 + EXP_W + MAN_W,
  localparam int M  = MAN_W + 1,
  localparam int SW = M + GRS_W,
  localparam int EW = EXP_W + 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic         out_valid_o,
  output logic [W-1:0] sum_o,
  output logic         ovf_o,
  output logic         unf_o
);
  // stage 1: unpack and align
  logic             al_sign, al_sub, al_zero;
  logic [EXP_W-1:0] al_exp;
  logic [SW-1:0]    al_big, al_small;

  fpa_align #(.EXP_W(EXP_W), .MAN_W(MAN_W)) i_align (
    .a_i(a_i), .b_i(b_i), .sub_i(sub_i),
    .sign_o(al_sign), .exp_o(al_exp), .big_o(al_big), .small_o(al_small),
    .eff_sub_o(al_sub), .zero_o(al_zero)
  );

  logic             s1_valid, s1_sign, s1_sub, s1_zero;
  logic [EXP_W-1:0] s1_exp;
  logic [SW-1:0]    s1_big, s1_small;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_sign  <= 1'b0;
      s1_sub   <= 1'b0;
      s1_zero  <= 1'b0;
      s1_exp   <= '0;
      s1_big   <= '0;
      s1_small <= '0;
    end else begin
      s1_valid <= in_valid_i;
      if (in_valid_i) begin
        s1_sign  <= al_sign;
        s1_sub   <= al_sub;
        s1_zero  <= al_zero;
        s1_exp   <= al_exp;
        s1_big   <= al_big;
        s1_small <= al_small;
      end
    end
  end

  // stage 2: add and renormalise
  logic                 an_sign, an_zero;
  logic signed [EW-1:0] an_exp;
  logic [SW-1:0]        an_norm;

  fpa_addnorm #(.EXP_W(EXP_W), .MAN_W(MAN_W)) i_addnorm (
    .sign_i(s1_sign), .exp_i(s1_exp), .big_i(s1_big), .small_i(s1_small),
    .eff_sub_i(s1_sub), .zero_i(s1_zero),
    .sign_o(an_sign), .exp_o(an_exp), .norm_o(an_norm), .zero_o(an_zero)
  );

  logic                 s2_valid, s2_sign, s2_zero;
  logic signed [EW-1:0] s2_exp;
  logic [SW-1:0]        s2_norm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_valid <= 1'b0;
      s2_sign  <= 1'b0;
      s2_zero  <= 1'b0;
      s2_exp   <= '0;
      s2_norm  <= '0;
    end else begin
      s2_valid <= s1_valid;
      if (s1_valid) begin
        s2_sign <= an_sign;
        s2_zero <= an_zero;
        s2_exp  <= an_exp;
        s2_norm <= an_norm;
      end
    end
  end

  // stage 3: round, range check, pack
  logic [W-1:0] rd_res;
  logic         rd_ovf, rd_unf;

  fpa_round #(.EXP_W(EXP_W), .MAN_W(MAN_W)) i_round (
    .sign_i(s2_sign), .exp_i(s2_exp), .norm_i(s2_norm), .zero_i(s2_zero),
    .res_o(rd_res), .ovf_o(rd_ovf), .unf_o(rd_unf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      sum_o       <= '0;
      ovf_o       <= 1'b0;
      unf_o       <= 1'b0;
    end else begin
      out_valid_o <= s2_valid;
      ovf_o       <= s2_valid & rd_ovf;
      unf_o       <= s2_valid & rd_unf;
      if (s2_valid) sum_o <= rd_res;
    end
  end
endmodule

// File: rtl/fpa_add_chk.sv
module fpa_add_chk #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         in_valid_i,
  input logic         out_valid_o,
  input logic [W-1:0] sum_o,
  input logic         ovf_o,
  input logic         unf_o
);
  logic [2:0] vsr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vsr <= '0;
    else         vsr <= {vsr[1:0], in_valid_i};
  end

  assert_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o == vsr[2]);

  assert_flag_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o || unf_o) |-> out_valid_o);

  assert_ovf_inf_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> (sum_o[MAN_W +: EXP_W] == '1) && (sum_o[MAN_W-1:0] == '0));

  assert_flags_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ovf_o && unf_o));

  assert_unf_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |-> (sum_o[W-2:0] == '0));

  assert_no_exp_max_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !ovf_o) |-> (sum_o[MAN_W +: EXP_W] != '1));

  assert_clean_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && sum_o[MAN_W +: EXP_W] == '0) |-> (sum_o[MAN_W-1:0] == '0));
endmodule

bind fp_add_rne fpa_add_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i),
  .out_valid_o(out_valid_o), .sum_o(sum_o), .ovf_o(ovf_o), .unf_o(unf_o)
);

// File: tb/test_fp_add_rne.sv
module test_fp_add_rne;
  localparam int NV = 19;
  // {tag, a, b, sub, expected sum, ovf, unf}
  localparam logic [106:0] VEC [NV] = '{
    {8'd3,  32'h3F000000, 32'hBEE00000, 1'b0, 32'h3D800000, 1'b0, 1'b0}, // R3 0.5 + -0.4375
    {8'd3,  32'hBEE00000, 32'h3F000000, 1'b0, 32'h3D800000, 1'b0, 1'b0}, // R3 swapped order
    {8'd1,  32'h3E800000, 32'h3F800000, 1'b1, 32'hBF400000, 1'b0, 1'b0}, // R1 -0.75 encoding
    {8'd4,  32'h3F800000, 32'h3E800000, 1'b1, 32'h3F400000, 1'b0, 1'b0}, // R4 1.0 - 0.25
    {8'd3,  32'h3FC00000, 32'h3FC00000, 1'b0, 32'h40400000, 1'b0, 1'b0}, // R3 carry renorm
    {8'd5,  32'h3F800000, 32'h33800000, 1'b0, 32'h3F800000, 1'b0, 1'b0}, // R5 tie, even stays
    {8'd5,  32'h3F800001, 32'h33800000, 1'b0, 32'h3F800002, 1'b0, 1'b0}, // R5 tie, odd goes up
    {8'd6,  32'h3F800000, 32'h33800001, 1'b0, 32'h3F800001, 1'b0, 1'b0}, // R6 above half
    {8'd6,  32'h3F800000, 32'h33000000, 1'b0, 32'h3F800000, 1'b0, 1'b0}, // R6 below half
    {8'd6,  32'h3F800000, 32'h0D800000, 1'b0, 32'h3F800000, 1'b0, 1'b0}, // R6 huge shift
    {8'd6,  32'h3F800000, 32'h33800001, 1'b1, 32'h3F7FFFFF, 1'b0, 1'b0}, // R6 sticky in subtract
    {8'd7,  32'h3FFFFFFF, 32'h33800000, 1'b0, 32'h40000000, 1'b0, 1'b0}, // R7 round carry
    {8'd8,  32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 32'h7F800000, 1'b1, 1'b0}, // R8 +inf
    {8'd8,  32'hFF7FFFFF, 32'hFF7FFFFF, 1'b0, 32'hFF800000, 1'b1, 1'b0}, // R8 -inf
    {8'd8,  32'h7F7FFFFF, 32'h73000000, 1'b0, 32'h7F800000, 1'b1, 1'b0}, // R8 via rounding
    {8'd9,  32'h80800001, 32'h00800000, 1'b0, 32'h80000000, 1'b0, 1'b1}, // R9 signed flush
    {8'd10, 32'hC0400000, 32'hC0400000, 1'b1, 32'h00000000, 1'b0, 1'b0}, // R10 x - x = +0
    {8'd10, 32'h00000001, 32'h3F800000, 1'b0, 32'h3F800000, 1'b0, 1'b0}, // R10 exp 0 is zero
    {8'd10, 32'h80000000, 32'h80000000, 1'b0, 32'h00000000, 1'b0, 1'b0}  // R10 -0 + -0 = +0
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [31:0] a_i = '0, b_i = '0;
  logic        sub_i = 1'b0;
  logic        out_valid_o, ovf_o, unf_o;
  logic [31:0] sum_o;
  int          checks = 0, failures = 0;
  bit          done = 1'b0;

  always #2 clk_i = ~clk_i;

  fp_add_rne i_fp_add_rne (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i),
    .a_i(a_i), .b_i(b_i), .sub_i(sub_i),
    .out_valid_o(out_valid_o), .sum_o(sum_o), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  task automatic check(input string req, input logic [34:0] act, input logic [34:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual={v,sum,ovf,unf}=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input int i);
    in_valid_i = 1'b1;
    a_i   = VEC[i][98:67];
    b_i   = VEC[i][66:35];
    sub_i = VEC[i][34];
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R2 reset", {out_valid_o, sum_o, ovf_o, unf_o}, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R2 idle after reset", {out_valid_o, sum_o, ovf_o, unf_o}, '0);

    // back-to-back stream
    for (int k = 0; k < NV + 3; k++) begin
      @(negedge clk_i);
      if (k >= 3)
        check($sformatf("R%0d vec%0d", VEC[k-3][106:99], k - 3),
              {out_valid_o, sum_o, ovf_o, unf_o},
              {1'b1, VEC[k-3][33:2], VEC[k-3][1], VEC[k-3][0]});
      if (k < NV) drive(k);
      else        in_valid_i = 1'b0;
    end
    @(negedge clk_i);
    check("R2 drain", {out_valid_o, ovf_o, unf_o, 32'h0}, '0);

    // single issue: exact three-cycle latency (R2) on the R7 carry case
    drive(11);
    @(negedge clk_i);
    in_valid_i = 1'b0;
    check("R2 lat1", {34'h0, out_valid_o}, '0);
    @(negedge clk_i);
    check("R2 lat2", {34'h0, out_valid_o}, '0);
    @(negedge clk_i);
    check("R2 lat3 R7", {out_valid_o, sum_o, ovf_o, unf_o}, {1'b1, 32'h40000000, 2'b00});
    @(negedge clk_i);
    check("R2 single pulse", {34'h0, out_valid_o}, '0);

    // overflow then a normal result: flags must clear (R8)
    drive(14);
    @(negedge clk_i);
    drive(3);
    @(negedge clk_i);
    in_valid_i = 1'b0;
    @(negedge clk_i);
    check("R8 ovf slot", {out_valid_o, sum_o, ovf_o, unf_o}, {1'b1, 32'h7F800000, 2'b10});
    @(negedge clk_i);
    check("R8 flag clears", {out_valid_o, sum_o, ovf_o, unf_o}, {1'b1, 32'h3F400000, 2'b00});

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule